// File: doc/BRIEF.md
# Serial Port Interrupt Status Controller

This block collects single-cycle event pulses from the transmit and receive paths of a serial port. Each pulse sets a sticky status bit. A matching enable register selects which of those bits may raise an interrupt. Software reads both registers through a small register port and clears status bits by writing ones to them.

A mode input chooses how the interrupt request leaves the block:
- **Combined mode:** one line carries every enabled source.
- **Split mode:** a receive line, a transmit line and a common line are all driven.

The four sources are:
- receive underflow
- transmit underflow
- transmit overflow
- transmit buffer empty at the end of a frame

Detecting these conditions is left to the datapath that feeds the block.

Top module: `sp_irq_ctrl`

## Requirements
- R1: After reset both registers read zero and `irq_common`, `irq_rx` and `irq_tx` are low.
- R2: An event pulse sampled at a rising edge sets its status bit from that edge on, and the bit then stays set until software clears it. The status bits sit at these positions: receive underflow at bit 4, transmit underflow at bit 11, transmit overflow at bit 12, transmit empty at end of frame at bit 14.
- R3: A write to address 0 (status) clears every status bit whose `reg_wdata` bit is one. Bits written with zero keep their value.
- R4: When an event pulse and a write-one clear of the same status bit fall on the same edge, the bit ends up set.
- R5: Address 1 holds the enable register. Only bits 4, 11, 12 and 14 are storage there; every other bit of either register reads zero. `reg_rdata` shows the register selected by `reg_addr` combinationally.
- R6: With `irq_mode` = 0 (combined), `irq_common` is high exactly when some status bit and its enable bit are both one, and `irq_rx` and `irq_tx` stay low.
- R7: With `irq_mode` = 1 (split), three conditions hold:
  - `irq_rx` is high exactly when bit 4 is both set and enabled.
  - `irq_tx` is high exactly when any of bits 11, 12 and 14 is both set and enabled.
  - `irq_common` is the OR over all enabled, set bits.
- R8: A status bit is recorded even while its enable bit is zero. A disabled bit does not affect any interrupt line.
- R9: A write to the status address leaves the enable register unchanged, and a write to the enable address leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_udf | input | 1 | Receive underflow event pulse |
| ev_tx_udf | input | 1 | Transmit underflow event pulse |
| ev_tx_ovf | input | 1 | Transmit overflow event pulse |
| ev_tx_eof_empty | input | 1 | Transmit buffer empty at end of frame pulse |
| irq_mode | input | 1 | 0 = combined line, 1 = split receive/transmit/common lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq_common | output | 1 | Common interrupt line |
| irq_rx | output | 1 | Receive interrupt line (split mode) |
| irq_tx | output | 1 | Transmit interrupt line (split mode) |

## Verification
The bench drives an event and a write-one clear of the same bit on the same edge. A design that let the clear win would lose that event and read the bit back as zero.

It writes all ones to the enable address to expose any stray storage at unmapped positions. It also writes all ones to the status address to catch a decoder that disturbs the other register.

Both modes are tried with only receive or only transmit sources enabled. A router that mixed the sides, or drove the side lines in combined mode, would raise the wrong line. Long stretches of random traffic then compare every output on every cycle against a behavioural model.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned NUM_SRC = 4;
    // source index: 0 rx underflow, 1 tx underflow, 2 tx overflow, 3 tx empty at end of frame
    localparam int unsigned SRC_POS   [NUM_SRC] = '{4, 11, 12, 14};
    localparam bit          SRC_IS_RX [NUM_SRC] = '{1'b1, 1'b0, 1'b0, 1'b0};

    typedef enum logic {
        IRQ_COMBINED = 1'b0,
        IRQ_SPLIT    = 1'b1
    } irq_mode_e;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_ENABLE = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/sp_irq_status_bank.sv
module sp_irq_status_bank #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] stat_q
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: an event in the same cycle wins
        st_d.stat = (st_q.stat & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> stat_q[i]);
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && clr[i]) |=> stat_q[i]);
        p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !stat_q[i]);
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !ev[i]) |=> $stable(stat_q[i]));
    end
endmodule

// File: rtl/sp_irq_enable_reg.sv
module sp_irq_enable_reg #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] en_q
);
    typedef struct packed {
        logic [NSRC-1:0] en;
    } enr_t;

    enr_t er_d, er_q;

    always_comb begin
        er_d = er_q;
        if (wr) er_d.en = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) er_q <= '0;
        else        er_q <= er_d;
    end

    assign en_q = er_q.en;

    p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en_q));
    p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en_q == $past(wbits)));
endmodule

// File: rtl/sp_irq_router.sv
module sp_irq_router
    import sp_irq_pkg::*;
#(
    parameter int unsigned NSRC = 4,
    parameter logic [NSRC-1:0] RX_MASK = 4'b0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] stat,
    input  logic [NSRC-1:0] en,
    input  logic            mode,
    output logic            irq_common,
    output logic            irq_rx,
    output logic            irq_tx
);
    logic [NSRC-1:0] live;
    logic            split;

    always_comb begin
        live       = stat & en;
        split      = (mode == IRQ_SPLIT);
        irq_common = |live;
        irq_rx     = split && |(live & RX_MASK);
        irq_tx     = split && |(live & ~RX_MASK);
    end

    p_combined_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == IRQ_COMBINED) |-> (!irq_rx && !irq_tx));
    p_common_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx || irq_tx) |-> irq_common);
    p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_common);
endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
    import sp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_udf,
    input  logic              ev_tx_udf,
    input  logic              ev_tx_ovf,
    input  logic              ev_tx_eof_empty,
    input  logic              irq_mode,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_common,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] rx_mask;
    logic               wr_stat;
    logic               wr_en;

    assign ev_vec = {ev_tx_eof_empty, ev_tx_ovf, ev_tx_udf, ev_rx_udf};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
        assign wbits[i]   = reg_wdata[SRC_POS[i]];
        assign clr_vec[i] = wr_stat & wbits[i];
        assign rx_mask[i] = SRC_IS_RX[i];
    end

    assign wr_stat = reg_wr && (reg_addr == ADDR_STATUS);
    assign wr_en   = reg_wr && (reg_addr == ADDR_ENABLE);

    sp_irq_status_bank #(.NSRC(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .clr    (clr_vec),
        .stat_q (stat_q)
    );

    sp_irq_enable_reg #(.NSRC(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en),
        .wbits (wbits),
        .en_q  (en_q)
    );

    sp_irq_router #(.NSRC(NUM_SRC), .RX_MASK(4'b0001)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat       (stat_q),
        .en         (en_q),
        .mode       (irq_mode),
        .irq_common (irq_common),
        .irq_rx     (irq_rx),
        .irq_tx     (irq_tx)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            reg_rdata[SRC_POS[i]] = (reg_addr == ADDR_ENABLE) ? en_q[i] : stat_q[i];
        end
    end

    p_status_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ev_vec == '0) |=> $stable(stat_q));
    p_rx_line_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (stat_q[0] && en_q[0]));
endmodule

// File: tb/sp_irq_ctrl_tb.sv
module sp_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx_udf = 1'b0, ev_tx_udf = 1'b0, ev_tx_ovf = 1'b0, ev_tx_eof_empty = 1'b0;
    logic        irq_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_common, irq_rx, irq_tx;

    localparam logic [15:0] MAP_ALL = 16'h5810;
    localparam logic [15:0] MAP_RX  = 16'h0010;
    localparam logic [15:0] MAP_TX  = 16'h5800;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_stat = '0;
    logic [15:0] m_en   = '0;

    always #5 clk = ~clk;

    sp_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_udf(ev_rx_udf), .ev_tx_udf(ev_tx_udf), .ev_tx_ovf(ev_tx_ovf),
        .ev_tx_eof_empty(ev_tx_eof_empty), .irq_mode(irq_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_common(irq_common), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    function automatic logic [15:0] ev_bits(input logic [3:0] ev);
        logic [15:0] b = '0;
        b[4]  = ev[0];
        b[11] = ev[1];
        b[12] = ev[2];
        b[14] = ev[3];
        return b;
    endfunction

    task automatic compare(input string tag);
        logic [15:0] live;
        logic [15:0] exp_rd;
        logic        e_c, e_r, e_t;
        live   = m_stat & m_en;
        exp_rd = reg_addr ? m_en : m_stat;
        e_c    = |live;
        e_r    = irq_mode && |(live & MAP_RX);
        e_t    = irq_mode && |(live & MAP_TX);
        checks++;
        if (reg_rdata !== exp_rd || irq_common !== e_c || irq_rx !== e_r || irq_tx !== e_t) begin
            errors++;
            $display("FAIL %s: rdata=%h common=%b rx=%b tx=%b expected rdata=%h common=%b rx=%b tx=%b",
                     tag, reg_rdata, irq_common, irq_rx, irq_tx, exp_rd, e_c, e_r, e_t);
        end
    endtask

    // drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(input string tag, input logic [3:0] ev, input logic wr,
                        input logic addr, input logic [15:0] wd, input logic mode);
        logic [15:0] n_stat;
        logic [15:0] n_en;
        {ev_tx_eof_empty, ev_tx_ovf, ev_tx_udf, ev_rx_udf} = ev;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd; irq_mode = mode;
        n_stat = m_stat;
        n_en   = m_en;
        if (wr && !addr) n_stat = n_stat & ~(wd & MAP_ALL);
        n_stat = n_stat | ev_bits(ev);
        if (wr && addr) n_en = wd & MAP_ALL;
        @(posedge clk);
        m_stat = n_stat;
        m_en   = n_en;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset under reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");
        step("R1 enable reads zero", 4'b0000, 1'b0, 1'b1, 16'h0000, 1'b0);

        // R8: events recorded with enables off, lines quiet
        step("R8 rx udf disabled", 4'b0001, 1'b0, 1'b0, '0, 1'b1);
        step("R2 tx udf sets bit 11", 4'b0010, 1'b0, 1'b0, '0, 1'b1);
        step("R2 tx ovf sets bit 12", 4'b0100, 1'b0, 1'b0, '0, 1'b1);
        step("R2 tx eof sets bit 14", 4'b1000, 1'b0, 1'b0, '0, 1'b1);
        step("R2 sticky hold", 4'b0000, 1'b0, 1'b0, '0, 1'b1);

        // R3: partial clear
        step("R3 clear 11 and 4", 4'b0000, 1'b1, 1'b0, 16'h0810, 1'b0);
        step("R3 zeros keep bits", 4'b0000, 1'b1, 1'b0, 16'h0000, 1'b0);

        // R4: set wins
        step("R4 set vs clear bit 12", 4'b0100, 1'b1, 1'b0, 16'h1000, 1'b0);
        step("R4 readback", 4'b0000, 1'b0, 1'b0, '0, 1'b0);

        // R5: enable map
        step("R5 enable all ones", 4'b0000, 1'b1, 1'b1, 16'hFFFF, 1'b0);
        step("R5 enable readback", 4'b0000, 1'b0, 1'b1, '0, 1'b0);
        step("R6 combined line", 4'b0000, 1'b0, 1'b0, '0, 1'b0);

        // R9: status write leaves enable; enable write leaves status
        step("R9 status w1c all", 4'b0000, 1'b1, 1'b0, 16'hFFFF, 1'b0);
        step("R9 enable intact", 4'b0000, 1'b0, 1'b1, '0, 1'b0);
        step("R9 set rx udf", 4'b0001, 1'b0, 1'b0, '0, 1'b0);
        step("R9 enable write", 4'b0000, 1'b1, 1'b1, 16'h0010, 1'b0);
        step("R9 status intact", 4'b0000, 1'b0, 1'b0, '0, 1'b0);

        // R7: split mode, receive only then transmit only
        step("R7 split rx only", 4'b0010, 1'b0, 1'b0, '0, 1'b1);
        step("R7 enable tx only", 4'b0000, 1'b1, 1'b1, 16'h0800, 1'b1);
        step("R7 split tx only", 4'b0000, 1'b0, 1'b0, '0, 1'b1);
        step("R6 combined again", 4'b0000, 1'b0, 1'b0, '0, 1'b0);
        step("R8 disabled source", 4'b0000, 1'b1, 1'b0, 16'h0800, 1'b1);

        for (int k = 0; k < 400; k++) begin
            logic [3:0]  ev = 4'($urandom) & 4'($urandom);
            logic        wr = 1'($urandom);
            logic        ad = 1'($urandom);
            logic [15:0] wd = 16'($urandom);
            logic        md = 1'($urandom);
            step("R2 random traffic", ev, wr, ad, wd, md);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule